// File: doc/BRIEF.md
# Multicore Boot Release Controller

This block decides, after every device-level reset, which of the three cores of a processor may leave reset and at which address each one begins fetching. Three reset inputs count as device-level: power-on, warm and system. The controller samples a 4-bit boot mode from configuration pins on the first clock after all three are deasserted. It then holds that value in a status field that core 0 reads to pick its software boot path. Local resets of individual cores are taken in but do not disturb any state of the controller.

A boot mode of zero means no-boot. All cores are released together and start from their local L2 RAM. Any other value means ROM boot. Only core 0 is released, and it starts at the boot ROM base. Cores 1 and 2 stay held until core 0 writes its event-assert register with the release bit set. That release is one-shot: it can happen only once between device-level resets.

Three named states carry the sequence. `ST_SAMPLE` is entered on any device-level reset. On the first clock after reset it takes the `to_all` transition when the mode is zero, or the `to_primary` transition otherwise. `ST_PRIMARY_ONLY` takes the `release_write` transition to `ST_ALL_RELEASED` on a write with the release bit set. `ST_ALL_RELEASED` has only its `hold` self-loop, so it can be left only through a device-level reset.

Top module: `boot_release_ctrl`

## Requirements
- R1: While any of `por_n`, `warm_rst_n` or `sys_rst_n` is low, `core_run` is 000 and `boot_mode_stat` is 0000.
- R2: With `boot_mode_pins` = 0000 when reset ends, `core_run` becomes 111 on the first rising clock edge after reset deasserts. All three start addresses are then L2_BASE (default 0x0080_0000).
- R3: With nonzero `boot_mode_pins` when reset ends, `core_run` becomes 001 on the first rising clock edge after reset deasserts. The core 0 start address (`core_start[31:0]`) is ROM_BASE (default 0x0010_0000).
- R4: In ROM boot with only core 0 running, a write (`evt_wr_en` = 1) whose data has bit 4 set changes `core_run` to 111 at the next rising edge. Cores 1 and 2 then present start address L2_BASE (`core_start[63:32]` and `core_start[95:64]`).
- R5: Once cores 1 and 2 are released, further writes with bit 4 set leave `core_run` at 111.
- R6: A write with bit 4 clear does not change `core_run`, whatever the other data bits are.
- R7: Toggling any bit of `local_rst_n` changes neither `core_run` nor `boot_mode_stat`. It also does not use up the pending one-shot release.
- R8: `boot_mode_stat` shows the mode sampled at the end of reset and ignores later changes on `boot_mode_pins`.
- R9: A bit of `core_run` stays high, once set, until the next device-level reset.
- R10: Each of the three device-level resets alone restarts the sequence and re-arms the one-shot release.
- R11: In no-boot mode a write with bit 4 set has no effect on `core_run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| warm_rst_n | input | 1 | Warm reset, active low |
| sys_rst_n | input | 1 | System reset, active low |
| local_rst_n | input | 3 | Per-core local resets, active low, no effect on the controller |
| boot_mode_pins | input | 4 | Boot mode configuration pins |
| evt_wr_en | input | 1 | Core 0 write strobe to the event-assert register |
| evt_wr_data | input | 32 | Write data; bit 4 requests release of cores 1 and 2 |
| core_run | output | 3 | Per-core reset release, bit n for core n, high = running |
| core_start | output | 96 | Start addresses, 32 bits per core, core 0 in the low word |
| boot_mode_stat | output | 4 | Latched boot mode status |

## Verification
A wrong state shows at `core_run` within one clock. A state stuck in `ST_SAMPLE` leaves the cores held. A state that wrongly leaves `ST_PRIMARY_ONLY` raises bits 1 and 2 early. A state that leaves `ST_ALL_RELEASED` drops a running core. A wrong latched mode appears directly on `boot_mode_stat` and on the core 0 start address in the same cycle. The directed cases therefore sample the outputs one edge after each reset release and after each write.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [1:0] {
        ST_SAMPLE       = 2'd0,
        ST_PRIMARY_ONLY = 2'd1,
        ST_ALL_RELEASED = 2'd2
    } brc_state_e;
endpackage

// File: rtl/brc_mode_latch.sv
module brc_mode_latch #(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [MODE_W-1:0] mode_pins,
    output logic [MODE_W-1:0] mode_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= '0;
        else if (sample_en)
            mode_q <= mode_pins;
    end
endmodule

// File: rtl/brc_release_fsm.sv
module brc_release_fsm
    import brc_pkg::*;
#(
    parameter int NUM_CORES = 3,
    parameter int MODE_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    mode_pins,
    input  logic                 rel_hit,
    output logic                 sample_en,
    output logic [NUM_CORES-1:0] core_run
);
    brc_state_e state_q, state_d;

    // next-state logic; transitions named to_all, to_primary, release_write, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE:       state_d = (mode_pins == '0) ? ST_ALL_RELEASED : ST_PRIMARY_ONLY;
            ST_PRIMARY_ONLY: state_d = rel_hit ? ST_ALL_RELEASED : ST_PRIMARY_ONLY;
            ST_ALL_RELEASED: state_d = ST_ALL_RELEASED;
            default:         state_d = ST_SAMPLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_SAMPLE;
        else
            state_q <= state_d;
    end

    assign sample_en = (state_q == ST_SAMPLE);

    // registered release outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_run <= '0;
        end else begin
            unique case (state_d)
                ST_SAMPLE:       core_run <= '0;
                ST_PRIMARY_ONLY: core_run <= NUM_CORES'(1);
                ST_ALL_RELEASED: core_run <= '1;
                default:         core_run <= '0;
            endcase
        end
    end
endmodule

// File: rtl/brc_addr_sel.sv
module brc_addr_sel #(
    parameter int          NUM_CORES = 3,
    parameter int          MODE_W    = 4,
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] ROM_BASE  = 32'h0010_0000,
    parameter logic [31:0] L2_BASE   = 32'h0080_0000
) (
    input  logic [MODE_W-1:0]           mode_q,
    output logic [NUM_CORES*ADDR_W-1:0] core_start
);
    localparam logic [ADDR_W-1:0] ROM_A = ADDR_W'(ROM_BASE);
    localparam logic [ADDR_W-1:0] L2_A  = ADDR_W'(L2_BASE);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        if (c == 0) begin : g_primary
            assign core_start[c*ADDR_W +: ADDR_W] = (mode_q == '0) ? L2_A : ROM_A;
        end else begin : g_secondary
            assign core_start[c*ADDR_W +: ADDR_W] = L2_A;
        end
    end
endmodule

// File: rtl/boot_release_ctrl.sv
module boot_release_ctrl #(
    parameter int          NUM_CORES   = 3,
    parameter int          MODE_W      = 4,
    parameter int          ADDR_W      = 32,
    parameter int          EVT_W       = 32,
    parameter int          REL_BIT     = 4,
    parameter logic [31:0] ROM_BASE    = 32'h0010_0000,
    parameter logic [31:0] L2_BASE     = 32'h0080_0000
) (
    input  logic                        clk,
    input  logic                        por_n,
    input  logic                        warm_rst_n,
    input  logic                        sys_rst_n,
    input  logic [NUM_CORES-1:0]        local_rst_n,
    input  logic [MODE_W-1:0]           boot_mode_pins,
    input  logic                        evt_wr_en,
    input  logic [EVT_W-1:0]            evt_wr_data,
    output logic [NUM_CORES-1:0]        core_run,
    output logic [NUM_CORES*ADDR_W-1:0] core_start,
    output logic [MODE_W-1:0]           boot_mode_stat
);
    logic dev_rst_n;
    logic sample_en;
    logic rel_hit;

    // only device-level resets reach the controller state
    assign dev_rst_n = por_n & warm_rst_n & sys_rst_n;
    assign rel_hit   = evt_wr_en & evt_wr_data[REL_BIT];

    brc_mode_latch #(.MODE_W(MODE_W)) u_latch (
        .clk       (clk),
        .rst_n     (dev_rst_n),
        .sample_en (sample_en),
        .mode_pins (boot_mode_pins),
        .mode_q    (boot_mode_stat)
    );

    brc_release_fsm #(.NUM_CORES(NUM_CORES), .MODE_W(MODE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (dev_rst_n),
        .mode_pins (boot_mode_pins),
        .rel_hit   (rel_hit),
        .sample_en (sample_en),
        .core_run  (core_run)
    );

    brc_addr_sel #(
        .NUM_CORES (NUM_CORES),
        .MODE_W    (MODE_W),
        .ADDR_W    (ADDR_W),
        .ROM_BASE  (ROM_BASE),
        .L2_BASE   (L2_BASE)
    ) u_addr (
        .mode_q     (boot_mode_stat),
        .core_start (core_start)
    );
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
    parameter int          NUM_CORES = 3,
    parameter int          MODE_W    = 4,
    parameter int          ADDR_W    = 32,
    parameter int          EVT_W     = 32,
    parameter int          REL_BIT   = 4,
    parameter logic [31:0] ROM_BASE  = 32'h0010_0000
) (
    input logic                        clk,
    input logic                        dev_rst_n,
    input logic [NUM_CORES-1:0]        local_rst_n,
    input logic                        evt_wr_en,
    input logic [EVT_W-1:0]            evt_wr_data,
    input logic [NUM_CORES-1:0]        core_run,
    input logic [NUM_CORES*ADDR_W-1:0] core_start,
    input logic [MODE_W-1:0]           boot_mode_stat
);
    AST_RESET_HELD: assert property (@(posedge clk) !dev_rst_n |-> core_run == '0); // R1

    AST_NOBOOT_ALL: assert property (@(posedge clk) disable iff (!dev_rst_n)
        (core_run[0] && boot_mode_stat == '0) |-> core_run == '1); // R2

    AST_ROM_START: assert property (@(posedge clk) disable iff (!dev_rst_n)
        (core_run == NUM_CORES'(1)) |-> core_start[ADDR_W-1:0] == ADDR_W'(ROM_BASE)); // R3

    AST_SECONDARY_NEEDS_PRIMARY: assert property (@(posedge clk) disable iff (!dev_rst_n)
        (core_run[NUM_CORES-1:1] != '0) |-> core_run[0]); // R4

    AST_BIT_CLEAR_NO_RELEASE: assert property (@(posedge clk) disable iff (!dev_rst_n)
        (core_run == NUM_CORES'(1) && !(evt_wr_en && evt_wr_data[REL_BIT]))
        |=> core_run == NUM_CORES'(1)); // R6

    AST_LOCAL_RST_NO_EFFECT: assert property (@(posedge clk) disable iff (!dev_rst_n)
        (core_run[0] && !evt_wr_en && local_rst_n != '1) |=> $stable(core_run)); // R7

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!dev_rst_n)
        (core_run[0] && $past(core_run[0])) |-> $stable(boot_mode_stat)); // R8

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!dev_rst_n)
        $countones(core_run & ~$past(core_run)) == $countones(core_run) - $countones($past(core_run))); // R9
endmodule

bind boot_release_ctrl brc_checker #(
    .NUM_CORES (NUM_CORES),
    .MODE_W    (MODE_W),
    .ADDR_W    (ADDR_W),
    .EVT_W     (EVT_W),
    .REL_BIT   (REL_BIT),
    .ROM_BASE  (ROM_BASE)
) u_chk (
    .clk            (clk),
    .dev_rst_n      (dev_rst_n),
    .local_rst_n    (local_rst_n),
    .evt_wr_en      (evt_wr_en),
    .evt_wr_data    (evt_wr_data),
    .core_run       (core_run),
    .core_start     (core_start),
    .boot_mode_stat (boot_mode_stat)
);

// File: tb/boot_release_ctrl_tb.sv
module boot_release_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ROM_A = 32'h0010_0000;
    localparam logic [31:0] L2_A  = 32'h0080_0000;

    logic        clk = 0;
    logic        por_n = 0, warm_rst_n = 0, sys_rst_n = 0;
    logic [2:0]  local_rst_n = 3'b111;
    logic [3:0]  boot_mode_pins = 0;
    logic        evt_wr_en = 0;
    logic [31:0] evt_wr_data = 0;
    logic [2:0]  core_run;
    logic [95:0] core_start;
    logic [3:0]  boot_mode_stat;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_release_ctrl dut_i (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .sys_rst_n(sys_rst_n),
        .local_rst_n(local_rst_n), .boot_mode_pins(boot_mode_pins),
        .evt_wr_en(evt_wr_en), .evt_wr_data(evt_wr_data),
        .core_run(core_run), .core_start(core_start), .boot_mode_stat(boot_mode_stat)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // which: 0 = power-on, 1 = warm, 2 = system
    task automatic dev_reset(int which, logic [3:0] mode);
        @(negedge clk);
        boot_mode_pins = mode;
        case (which)
            0: por_n = 0;
            1: warm_rst_n = 0;
            default: sys_rst_n = 0;
        endcase
        repeat (2) @(negedge clk);
        check("R1", "run in reset", 32'(core_run), 32'h0);
        check("R1", "status in reset", 32'(boot_mode_stat), 32'h0);
        por_n = 1; warm_rst_n = 1; sys_rst_n = 1;
        #1;
        check("R1", "run before first edge", 32'(core_run), 32'h0);
        @(negedge clk);
    endtask

    task automatic write_evt(logic [31:0] data);
        evt_wr_en = 1; evt_wr_data = data;
        @(negedge clk);
        evt_wr_en = 0; evt_wr_data = 0;
    endtask

    task automatic t_noboot();
        dev_reset(0, 4'h0);
        check("R2", "run", 32'(core_run), 32'h7);
        check("R2", "core0 start", core_start[31:0], L2_A);
        check("R2", "core1 start", core_start[63:32], L2_A);
        check("R2", "core2 start", core_start[95:64], L2_A);
        write_evt(32'h10);
        check("R11", "run after write", 32'(core_run), 32'h7);
    endtask

    task automatic t_rom_release();
        dev_reset(0, 4'h5);
        check("R3", "run", 32'(core_run), 32'h1);
        check("R3", "core0 start", core_start[31:0], ROM_A);
        check("R8", "status", 32'(boot_mode_stat), 32'h5);
        boot_mode_pins = 4'hA;
        repeat (2) @(negedge clk);
        check("R8", "status after pin change", 32'(boot_mode_stat), 32'h5);
        write_evt(32'hFFFF_FFEF);
        check("R6", "run after bit4 clear", 32'(core_run), 32'h1);
        local_rst_n = 3'b000;
        repeat (2) @(negedge clk);
        local_rst_n = 3'b111;
        @(negedge clk);
        check("R7", "run after local reset", 32'(core_run), 32'h1);
        check("R7", "status after local reset", 32'(boot_mode_stat), 32'h5);
        write_evt(32'h0000_0010);
        check("R4", "run after release", 32'(core_run), 32'h7);
        check("R4", "core1 start", core_start[63:32], L2_A);
        check("R4", "core2 start", core_start[95:64], L2_A);
        write_evt(32'h0000_0010);
        check("R5", "run after second write", 32'(core_run), 32'h7);
        local_rst_n = 3'b010;
        repeat (5) @(negedge clk);
        local_rst_n = 3'b111;
        check("R9", "run held", 32'(core_run), 32'h7);
    endtask

    task automatic t_rearm(int which, logic [3:0] mode);
        dev_reset(which, mode);
        check("R10", "run after restart", 32'(core_run), 32'h1);
        check("R10", "status after restart", 32'(boot_mode_stat), 32'(mode));
        write_evt(32'h0000_0010);
        check("R10", "release re-armed", 32'(core_run), 32'h7);
    endtask

    initial begin
        t_noboot();
        t_rom_release();
        t_rearm(1, 4'h3);
        t_rearm(2, 4'hF);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule